// File: doc/BRIEF.md
# CAN Controller Initialization Sequencer

This block governs when a CAN protocol controller may take part in bus traffic. It owns the init and configuration-change enable control bits. It also holds the two bit-timing registers, the main timing word and the prescaler extension. When init is released it runs a bus-integration phase: the bit stream engine stays disabled until the receive line has been idle for a fixed number of bit times.

Init is entered in three ways: a software write, a hardware reset, or a bus-off indication from error management. Only a software write can leave init. While init is set, the transmit pin is forced recessive and the bit stream engine is disabled. The timing registers accept writes only while both init and the configuration-change bit are set. Entering init never alters the timing registers. A bus-off event does not start integration on its own; integration begins only after software clears init again.

Top module: `can_init_seq`

## Requirements
- R1: After hardware reset: init_o=1, cce_o=0, btr_q_o=16'h2301, brpe_q_o=0, xfer_en_o=0, tx_force_rec_o=1.
- R2: A write to address 0 loads init from wr_data_i bit 0 and cce from bit 1. A high bus_off_i sets init on the next edge and takes priority over a write in the same cycle.
- R3: While init_o=1, tx_force_rec_o=1 and xfer_en_o=0. xfer_en_o drops in the same cycle that init_o becomes 1.
- R4: A write to address 1 (timing, bits 15:0) or address 2 (prescaler extension, bits 3:0) pulses btr_we_o or brpe_we_o and updates the register on the next edge, provided init_o=1 and cce_o=1.
- R5: Timing and prescaler writes made while init_o=0 or cce_o=0 are ignored: no write-enable pulse and no change in value. Writes to address 3 have no effect.
- R6: init_o returns to 0 only through a software write with bit 0 low. Removing bus_off_i does not clear it.
- R7: After init is cleared, xfer_en_o rises just after the strobe (bit_tick_i=1) that samples the 11th consecutive recessive (rx_bit_i=1) bit, and not before.
- R8: A dominant bit sampled during the idle count restarts the count from zero.
- R9: After a bus-off event, recessive bits sampled while init is still set do not count. Integration starts only after software clears init. The timing registers keep their values across the event.
- R10: rx_bit_i is ignored in cycles where bit_tick_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 timing, 2 prescaler ext, 3 reserved |
| wr_data_i | input | 16 | Write data |
| bus_off_i | input | 1 | Bus-off indication from error management |
| rx_bit_i | input | 1 | Sampled receive bit, 1 = recessive |
| bit_tick_i | input | 1 | One-cycle strobe per sampled bit |
| xfer_en_o | output | 1 | Transfer enable to the bit stream engine |
| tx_force_rec_o | output | 1 | Holds the transmit pin recessive |
| init_o | output | 1 | Init bit |
| cce_o | output | 1 | Configuration-change enable bit |
| btr_we_o | output | 1 | Accepted write to the timing register |
| brpe_we_o | output | 1 | Accepted write to the prescaler extension |
| btr_q_o | output | 16 | Timing register value |
| brpe_q_o | output | 4 | Prescaler extension value |

## Verification
The bench sends exactly ten recessive bits and then an eleventh. An off-by-one counter would enable transfer one bit early or one bit late. A dominant bit inserted mid-count catches a design that only pauses the count instead of restarting it. Recessive bits sent while bus-off holds init would, in a design that starts integration on its own, raise transfer enable with no software action. Timing writes with cce clear, and writes with bus_off arriving in the same cycle, expose a write gate or a set/clear priority that was built the wrong way.

// File: rtl/can_init_pkg.sv
package can_init_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_TIMING = 2'd1,
    ADDR_PRESC  = 2'd2,
    ADDR_RSVD   = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_INIT_BIT = 0;
  localparam int unsigned CTRL_CCE_BIT  = 1;
endpackage

// File: rtl/can_init_ctrl.sv
module can_init_ctrl
  import can_init_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bus_off_i,
  output logic              init_o,
  output logic              cce_o
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_o <= 1'b1;
      cce_o  <= 1'b0;
    end else begin
      // hardware set wins over software clear
      if (bus_off_i)    init_o <= 1'b1;
      else if (ctrl_wr) init_o <= wr_data_i[CTRL_INIT_BIT];
      if (ctrl_wr)      cce_o  <= wr_data_i[CTRL_CCE_BIT];
    end
  end
endmodule

// File: rtl/can_timing_reg.sv
module can_timing_reg #(
  parameter int unsigned       W   = 16,
  parameter logic [W-1:0]      RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/can_idle_detect.sv
module can_idle_detect #(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic bit_tick_i,
  input  logic rx_bit_i,
  output logic run_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (init_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!run_q && bit_tick_i) begin
      if (!rx_bit_i) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
        run_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // drop in the cycle init rises, not one later
  assign run_o = run_q && !init_i;
endmodule

// File: rtl/can_init_seq.sv
module can_init_seq
  import can_init_pkg::*;
#(
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       BTR_W     = 16,
  parameter int unsigned       BRPE_W    = 4,
  parameter int unsigned       IDLE_BITS = 11,
  parameter logic [BTR_W-1:0]  BTR_RST   = 16'h2301,
  parameter logic [BRPE_W-1:0] BRPE_RST  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bus_off_i,
  input  logic              rx_bit_i,
  input  logic              bit_tick_i,
  output logic              xfer_en_o,
  output logic              tx_force_rec_o,
  output logic              init_o,
  output logic              cce_o,
  output logic              btr_we_o,
  output logic              brpe_we_o,
  output logic [BTR_W-1:0]  btr_q_o,
  output logic [BRPE_W-1:0] brpe_q_o
);
  logic init_q, cce_q, cfg_open;

  can_init_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .bus_off_i,
    .init_o(init_q), .cce_o(cce_q)
  );

  assign cfg_open  = init_q && cce_q;
  assign btr_we_o  = cfg_open && wr_en_i && (wr_addr_i == ADDR_TIMING);
  assign brpe_we_o = cfg_open && wr_en_i && (wr_addr_i == ADDR_PRESC);

  can_timing_reg #(.W(BTR_W), .RST(BTR_RST)) u_btr (
    .clk_i, .rst_ni, .we_i(btr_we_o), .d_i(wr_data_i[BTR_W-1:0]), .q_o(btr_q_o)
  );

  can_timing_reg #(.W(BRPE_W), .RST(BRPE_RST)) u_brpe (
    .clk_i, .rst_ni, .we_i(brpe_we_o), .d_i(wr_data_i[BRPE_W-1:0]), .q_o(brpe_q_o)
  );

  can_idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i, .rst_ni, .init_i(init_q), .bit_tick_i, .rx_bit_i, .run_o(xfer_en_o)
  );

  assign init_o         = init_q;
  assign cce_o          = cce_q;
  assign tx_force_rec_o = init_q;
endmodule

// File: rtl/can_init_seq_chk.sv
module can_init_seq_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BTR_W  = 16,
  parameter int unsigned BRPE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              bus_off_i,
  input logic              rx_bit_i,
  input logic              bit_tick_i,
  input logic              xfer_en_o,
  input logic              tx_force_rec_o,
  input logic              init_o,
  input logic              cce_o,
  input logic              btr_we_o,
  input logic              brpe_we_o,
  input logic [BTR_W-1:0]  btr_q_o,
  input logic [BRPE_W-1:0] brpe_q_o
);
  p_bus_off_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_i |=> init_o);

  p_init_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |-> (tx_force_rec_o && !xfer_en_o));

  p_we_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btr_we_o || brpe_we_o) |-> (init_o && cce_o));

  p_btr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !btr_we_o |=> $stable(btr_q_o));

  p_brpe_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brpe_we_o |=> $stable(brpe_q_o));

  p_sw_clear_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_o && !(wr_en_i && wr_addr_i == 2'd0 && !wr_data_i[0])) |=> init_o);

  p_rise_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_en_o) |-> $past(bit_tick_i && rx_bit_i));
endmodule

bind can_init_seq can_init_seq_chk #(.DATA_W(DATA_W), .BTR_W(BTR_W), .BRPE_W(BRPE_W)) u_chk (.*);

// File: tb/tb_can_init_seq.sv
module tb_can_init_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        bus_off_i = 1'b0;
  logic        rx_bit_i = 1'b1;
  logic        bit_tick_i = 1'b0;
  logic        xfer_en_o, tx_force_rec_o, init_o, cce_o, btr_we_o, brpe_we_o;
  logic [15:0] btr_q_o;
  logic [3:0]  brpe_q_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  can_init_seq dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic bits(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      bit_tick_i = 1'b1; rx_bit_i = v;
      @(negedge clk_i);
      bit_tick_i = 1'b0; rx_bit_i = 1'b1;
    end
  endtask

  task automatic t_reset;
    chk("R1 init", init_o, 1);
    chk("R1 cce", cce_o, 0);
    chk("R1 btr", btr_q_o, 16'h2301);
    chk("R1 brpe", brpe_q_o, 0);
    chk("R1 xfer", xfer_en_o, 0);
    chk("R3 txrec", tx_force_rec_o, 1);
  endtask

  task automatic t_ignored_cfg;
    wr(2'd1, 16'h1111);
    chk("R5 btr cce=0", btr_q_o, 16'h2301);
    wr(2'd3, 16'h0003);
    chk("R5 addr3 init", init_o, 1);
    chk("R5 addr3 cce", cce_o, 0);
  endtask

  task automatic t_cfg_write;
    wr(2'd0, 16'h0003);
    chk("R2 cce set", cce_o, 1);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 16'h4A5C;
    #1 chk("R4 btr_we", btr_we_o, 1);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R4 btr val", btr_q_o, 16'h4A5C);
    wr(2'd2, 16'hFFF9);
    chk("R4 brpe val", brpe_q_o, 4'h9);
  endtask

  task automatic t_idle_basic;
    wr(2'd0, 16'h0000);
    chk("R6 sw clear", init_o, 0);
    chk("R3 txrec low", tx_force_rec_o, 0);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 16'h0BAD;
    #1 chk("R5 btr_we idle", btr_we_o, 0);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R5 btr unchanged", btr_q_o, 16'h4A5C);
    bits(10, 1'b1);
    chk("R7 ten bits", xfer_en_o, 0);
    bits(1, 1'b1);
    chk("R7 eleventh", xfer_en_o, 1);
  endtask

  task automatic t_sw_reinit_restart;
    wr(2'd0, 16'h0001);
    chk("R3 xfer drop", xfer_en_o, 0);
    chk("R2 sw set", init_o, 1);
    wr(2'd0, 16'h0000);
    bits(5, 1'b1);
    bits(1, 1'b0);
    bits(10, 1'b1);
    chk("R8 after dominant", xfer_en_o, 0);
    bits(1, 1'b1);
    chk("R8 full run", xfer_en_o, 1);
  endtask

  task automatic t_no_strobe;
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'h0000);
    bits(10, 1'b1);
    @(negedge clk_i);
    rx_bit_i = 1'b1;
    repeat (20) @(negedge clk_i);
    chk("R10 no tick", xfer_en_o, 0);
    bits(1, 1'b1);
    chk("R10 tick", xfer_en_o, 1);
  endtask

  task automatic t_bus_off;
    @(negedge clk_i);
    bus_off_i = 1'b1;
    @(negedge clk_i);
    bus_off_i = 1'b0;
    chk("R2 busoff init", init_o, 1);
    chk("R3 busoff xfer", xfer_en_o, 0);
    chk("R3 busoff txrec", tx_force_rec_o, 1);
    bits(20, 1'b1);
    chk("R6 stays init", init_o, 1);
    chk("R9 no auto start", xfer_en_o, 0);
    chk("R9 btr kept", btr_q_o, 16'h4A5C);
    chk("R9 brpe kept", brpe_q_o, 4'h9);
    // bus-off wins over simultaneous clear
    @(negedge clk_i);
    bus_off_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 16'h0000;
    @(negedge clk_i);
    bus_off_i = 1'b0; wr_en_i = 1'b0;
    chk("R2 priority", init_o, 1);
    wr(2'd0, 16'h0000);
    bits(10, 1'b1);
    chk("R9 ten after clear", xfer_en_o, 0);
    bits(1, 1'b1);
    chk("R9 start after clear", xfer_en_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ignored_cfg();
    t_cfg_write();
    t_idle_basic();
    t_sw_reinit_restart();
    t_no_strobe();
    t_bus_off();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule